// File: doc/BRIEF.md
# Pipeline Operand Bypass and Interlock Control

This combinational control block serves a five-stage in-order integer pipeline with the stages fetch, decode/register read, execute, memory and write-back. Register operands are read in decode and results are written in write-back. Every instruction visits every stage. For these reasons the only dependence the block has to resolve is a read that follows a write. It compares the source register numbers of the instructions in decode, execute and memory against the destination numbers and write flags of the younger and older in-flight results. From those comparisons it sets the selects of the two execute operand multiplexers, the memory-stage store-data multiplexer and the decode-stage branch comparator inputs.

When a bypass cannot supply a value in time, the block raises a single stall line. That line holds the PC and the fetch/decode register for one cycle and turns the decode/execute register into a no-op. This happens in three cases: a load feeds an ALU operand of the next instruction, a load feeds a branch being resolved in decode, or an ALU result feeds such a branch. Register 0 is hardwired to zero, so it never takes part in any of these comparisons.

Top module: `haz_fwd_unit`

## Requirements
- R1: An execute operand select (fwd_a_o for rs1, fwd_b_o for rs2) is 2'b10 when the memory-stage instruction writes a non-load result to a nonzero register that equals that source. The select encoding is 00 = register file, 01 = write-back value, 10 = memory-stage value.
- R2: An execute operand select is 2'b01 when the write-back instruction writes a nonzero register equal to that source and the memory-stage instruction does not write that register.
- R3: When both the memory-stage and write-back destinations match a source, the younger memory-stage result wins and the select is 2'b10.
- R4: A destination of register 0 never causes forwarding, comparator bypass, store-data bypass or a stall.
- R5: If the matching memory-stage instruction is a load, the execute operand select is 2'b00, and the older write-back value is not used.
- R6: stall_o is 1 when the execute instruction is a writing load with a nonzero destination equal to a decode source used as an ALU operand. That is rs1 when id_use_rs1_i is set, and rs2 when id_use_rs2_i is set and id_is_store_i is clear.
- R7: A store in decode whose rs2 (its data register) matches a load in execute, and whose rs1 does not, causes no stall.
- R8: st_fwd_o is 1 when the memory-stage instruction is a store and the write-back instruction writes a nonzero register equal to that store's data register.
- R9: A branch in decode stalls when the execute instruction writes a nonzero register equal to a used branch source.
- R10: A branch in decode stalls when the memory-stage instruction is a writing load with a nonzero destination equal to a used branch source.
- R11: cmp_a_o / cmp_b_o are 1 when the memory-stage instruction writes a non-load result to a nonzero register equal to id_rs1_i / id_rs2_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_W | Decode first source register |
| id_rs2_i | input | REG_W | Decode second source register |
| id_use_rs1_i | input | 1 | Decode instruction reads rs1 |
| id_use_rs2_i | input | 1 | Decode instruction reads rs2 |
| id_is_store_i | input | 1 | Decode instruction is a store (rs2 is data) |
| id_is_branch_i | input | 1 | Decode instruction is a branch resolved in decode |
| ex_rs1_i | input | REG_W | Execute first source register |
| ex_rs2_i | input | REG_W | Execute second source register |
| ex_rd_i | input | REG_W | Execute destination register |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_W | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| mem_rs2_i | input | REG_W | Memory-stage store data register |
| wb_rd_i | input | REG_W | Write-back destination register |
| wb_we_i | input | 1 | Write-back instruction writes a register |
| fwd_a_o | output | 2 | Execute operand A select |
| fwd_b_o | output | 2 | Execute operand B select |
| st_fwd_o | output | 1 | Store data taken from write-back value |
| cmp_a_o | output | 1 | Branch comparator A taken from memory-stage value |
| cmp_b_o | output | 1 | Branch comparator B taken from memory-stage value |
| stall_o | output | 1 | Hold PC and fetch/decode, bubble decode/execute |

## Verification
The bench builds the block with the default REG_W of 5. The random phase, however, draws every register number from 0 to 3. With so few registers, destinations collide with sources in most cycles, so double matches, load-versus-ALU priority and the register-0 exclusion come up constantly rather than rarely. Directed vectors reproduce the classic sequences first: back-to-back ALU use, load-use, load feeding a store, and the ALU and load producers of a branch.

// File: rtl/haz_fwd_pkg.sv
package haz_fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int REG_W = 5
) (
  input  logic             we_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] src_i,
  output logic             hit_o
);
  // register 0 is hardwired, never a producer
  assign hit_o = we_i && (rd_i != '0) && (rd_i == src_i);
endmodule

// File: rtl/hz_ex_fwd.sv
module hz_ex_fwd
  import haz_fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_ld_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);
  logic mem_hit, wb_hit;

  hz_match #(.REG_W(REG_W)) u_mem (.we_i(mem_we_i), .rd_i(mem_rd_i), .src_i(src_i), .hit_o(mem_hit));
  hz_match #(.REG_W(REG_W)) u_wb  (.we_i(wb_we_i),  .rd_i(wb_rd_i),  .src_i(src_i), .hit_o(wb_hit));

  always_comb begin
    if (mem_hit)     sel_o = mem_ld_i ? SEL_RF : SEL_MEM; // load data not ready yet
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_use_rs1_i,
  input  logic             id_use_rs2_i,
  input  logic             id_is_store_i,
  input  logic             id_is_branch_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_ld_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_ld_i,
  output logic             stall_o
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] src [NSRC];
  logic [NSRC-1:0]  used, alu_used, ex_hit, mem_hit;

  assign src[0]      = id_rs1_i;
  assign src[1]      = id_rs2_i;
  assign used        = {id_use_rs2_i, id_use_rs1_i};
  // store data is bypassed in the memory stage, not an ALU operand
  assign alu_used    = {id_use_rs2_i & ~id_is_store_i, id_use_rs1_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_match #(.REG_W(REG_W)) u_ex  (.we_i(ex_we_i), .rd_i(ex_rd_i), .src_i(src[g]), .hit_o(ex_hit[g]));
    hz_match #(.REG_W(REG_W)) u_mem (.we_i(mem_we_i & mem_ld_i), .rd_i(mem_rd_i), .src_i(src[g]), .hit_o(mem_hit[g]));
  end

  logic load_use, br_ex, br_mem;
  assign load_use = ex_ld_i && |(ex_hit & alu_used);
  assign br_ex    = id_is_branch_i && |(ex_hit & used);
  assign br_mem   = id_is_branch_i && |(mem_hit & used);
  assign stall_o  = load_use | br_ex | br_mem;
endmodule

// File: rtl/haz_fwd_unit.sv
module haz_fwd_unit
  import haz_fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_use_rs1_i,
  input  logic             id_use_rs2_i,
  input  logic             id_is_store_i,
  input  logic             id_is_branch_i,
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_is_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_is_load_i,
  input  logic             mem_is_store_i,
  input  logic [REG_W-1:0] mem_rs2_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             st_fwd_o,
  output logic             cmp_a_o,
  output logic             cmp_b_o,
  output logic             stall_o
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] ex_src [NSRC];
  logic [REG_W-1:0] id_src [NSRC];
  fwd_sel_e         ex_sel [NSRC];
  logic [NSRC-1:0]  cmp_hit;
  logic             st_hit;

  assign ex_src[0] = ex_rs1_i;
  assign ex_src[1] = ex_rs2_i;
  assign id_src[0] = id_rs1_i;
  assign id_src[1] = id_rs2_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    hz_ex_fwd #(.REG_W(REG_W)) u_fwd (
      .src_i(ex_src[g]), .mem_rd_i(mem_rd_i), .mem_we_i(mem_we_i), .mem_ld_i(mem_is_load_i),
      .wb_rd_i(wb_rd_i), .wb_we_i(wb_we_i), .sel_o(ex_sel[g])
    );
    // write-back value reaches decode through write-before-read register file
    hz_match #(.REG_W(REG_W)) u_cmp (
      .we_i(mem_we_i & ~mem_is_load_i), .rd_i(mem_rd_i), .src_i(id_src[g]), .hit_o(cmp_hit[g])
    );
  end

  hz_match #(.REG_W(REG_W)) u_st (.we_i(wb_we_i), .rd_i(wb_rd_i), .src_i(mem_rs2_i), .hit_o(st_hit));

  hz_stall #(.REG_W(REG_W)) u_stall (
    .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i), .id_use_rs1_i(id_use_rs1_i), .id_use_rs2_i(id_use_rs2_i),
    .id_is_store_i(id_is_store_i), .id_is_branch_i(id_is_branch_i),
    .ex_rd_i(ex_rd_i), .ex_we_i(ex_we_i), .ex_ld_i(ex_is_load_i),
    .mem_rd_i(mem_rd_i), .mem_we_i(mem_we_i), .mem_ld_i(mem_is_load_i),
    .stall_o(stall_o)
  );

  assign fwd_a_o  = ex_sel[0];
  assign fwd_b_o  = ex_sel[1];
  assign cmp_a_o  = cmp_hit[0];
  assign cmp_b_o  = cmp_hit[1];
  assign st_fwd_o = mem_is_store_i & st_hit;
endmodule

// File: rtl/haz_fwd_unit_chk.sv
module haz_fwd_unit_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] id_rs1_i,
  input logic             id_is_branch_i,
  input logic [REG_W-1:0] ex_rs1_i,
  input logic [REG_W-1:0] ex_rs2_i,
  input logic             ex_we_i,
  input logic             ex_is_load_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_we_i,
  input logic             mem_is_load_i,
  input logic             mem_is_store_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             wb_we_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             st_fwd_o,
  input logic             cmp_a_o,
  input logic             stall_o
);
  always_comb begin
    p_sel_legal_r1: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)
      else $error("illegal operand select");
    p_mem_src_r1: assert (fwd_a_o != 2'b10 || (mem_we_i && !mem_is_load_i && mem_rd_i == ex_rs1_i))
      else $error("memory-stage bypass without a matching ALU producer");
    p_wb_src_r2: assert (fwd_b_o != 2'b01 || (wb_we_i && wb_rd_i == ex_rs2_i))
      else $error("write-back bypass without a matching producer");
    p_zero_src_r4: assert (ex_rs1_i != '0 || fwd_a_o == 2'b00)
      else $error("register 0 bypassed");
    p_cmp_zero_r4: assert (id_rs1_i != '0 || !cmp_a_o)
      else $error("register 0 bypassed to comparator");
    p_stall_cause_r6: assert (!stall_o || (ex_we_i && ex_is_load_i) || id_is_branch_i)
      else $error("stall without load or branch");
    p_st_only_r8: assert (!st_fwd_o || mem_is_store_i)
      else $error("store bypass without a store");
  end
endmodule

bind haz_fwd_unit haz_fwd_unit_chk #(.REG_W(REG_W)) u_chk (
  .id_rs1_i(id_rs1_i), .id_is_branch_i(id_is_branch_i),
  .ex_rs1_i(ex_rs1_i), .ex_rs2_i(ex_rs2_i), .ex_we_i(ex_we_i), .ex_is_load_i(ex_is_load_i),
  .mem_rd_i(mem_rd_i), .mem_we_i(mem_we_i), .mem_is_load_i(mem_is_load_i),
  .mem_is_store_i(mem_is_store_i), .wb_rd_i(wb_rd_i), .wb_we_i(wb_we_i),
  .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .st_fwd_o(st_fwd_o), .cmp_a_o(cmp_a_o), .stall_o(stall_o)
);

// File: tb/haz_fwd_unit_test.sv
module haz_fwd_unit_test;
  localparam int CLK_P = 10;
  localparam int RW    = 5;
  localparam int LIMIT = 20000;

  typedef struct {
    int id_rs1, id_rs2, use1, use2, id_st, id_br;
    int ex_rs1, ex_rs2, ex_rd, ex_we, ex_ld;
    int mem_rd, mem_we, mem_ld, mem_st, mem_rs2;
    int wb_rd, wb_we;
  } vec_t;

  typedef struct { int rd; int we; int ld; } prod_t;

  logic clk = 0;
  always #(CLK_P/2) clk = ~clk;

  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_use1, id_use2, id_st, id_br, ex_we, ex_ld, mem_we, mem_ld, mem_st, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, cmp_a, cmp_b, stall;

  haz_fwd_unit #(.REG_W(RW)) uut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(id_use1), .id_use_rs2_i(id_use2),
    .id_is_store_i(id_st), .id_is_branch_i(id_br),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_is_load_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_is_load_i(mem_ld), .mem_is_store_i(mem_st),
    .mem_rs2_i(mem_rs2), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .st_fwd_o(st_fwd), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b),
    .stall_o(stall)
  );

  int total = 0, bad = 0;
  vec_t v;

  function automatic vec_t blank();
    vec_t b;
    b = '{default: 0};
    return b;
  endfunction

  // younger producer first; first live match decides
  function automatic int ref_sel(vec_t x, int src);
    prod_t q[$];
    q.push_back('{x.mem_rd, x.mem_we, x.mem_ld});
    q.push_back('{x.wb_rd, x.wb_we, 0});
    foreach (q[i]) begin
      if (q[i].we != 0 && q[i].rd != 0 && q[i].rd == src) begin
        if (i == 0) return (q[i].ld != 0) ? 0 : 2;
        return 1;
      end
    end
    return 0;
  endfunction

  function automatic int in_list(int r, int lst[$]);
    foreach (lst[i]) if (r != 0 && lst[i] == r) return 1;
    return 0;
  endfunction

  function automatic int ref_stall(vec_t x);
    int alu[$];
    int br[$];
    if (x.use1 != 0) begin alu.push_back(x.id_rs1); br.push_back(x.id_rs1); end
    if (x.use2 != 0) begin br.push_back(x.id_rs2); if (x.id_st == 0) alu.push_back(x.id_rs2); end
    if (x.ex_ld != 0 && x.ex_we != 0 && in_list(x.ex_rd, alu) != 0) return 1;
    if (x.id_br != 0) begin
      if (x.ex_we != 0 && in_list(x.ex_rd, br) != 0) return 1;
      if (x.mem_we != 0 && x.mem_ld != 0 && in_list(x.mem_rd, br) != 0) return 1;
    end
    return 0;
  endfunction

  function automatic int ref_cmp(vec_t x, int src);
    return (x.mem_we != 0 && x.mem_ld == 0 && x.mem_rd != 0 && x.mem_rd == src) ? 1 : 0;
  endfunction

  function automatic int ref_st(vec_t x);
    return (x.mem_st != 0 && x.wb_we != 0 && x.wb_rd != 0 && x.wb_rd == x.mem_rs2) ? 1 : 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(string tfwd, string tst, string tcmp, string tstall);
    @(negedge clk);
    id_rs1 = RW'(v.id_rs1); id_rs2 = RW'(v.id_rs2); id_use1 = v.use1[0]; id_use2 = v.use2[0];
    id_st = v.id_st[0]; id_br = v.id_br[0];
    ex_rs1 = RW'(v.ex_rs1); ex_rs2 = RW'(v.ex_rs2); ex_rd = RW'(v.ex_rd);
    ex_we = v.ex_we[0]; ex_ld = v.ex_ld[0];
    mem_rd = RW'(v.mem_rd); mem_we = v.mem_we[0]; mem_ld = v.mem_ld[0];
    mem_st = v.mem_st[0]; mem_rs2 = RW'(v.mem_rs2);
    wb_rd = RW'(v.wb_rd); wb_we = v.wb_we[0];
    #(CLK_P/4);
    chk(tfwd, "fwd_a", int'(fwd_a), ref_sel(v, v.ex_rs1));
    chk(tfwd, "fwd_b", int'(fwd_b), ref_sel(v, v.ex_rs2));
    chk(tst, "st_fwd", int'(st_fwd), ref_st(v));
    chk(tcmp, "cmp_a", int'(cmp_a), ref_cmp(v, v.id_rs1));
    chk(tcmp, "cmp_b", int'(cmp_b), ref_cmp(v, v.id_rs2));
    chk(tstall, "stall", int'(stall), ref_stall(v));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // idle pipeline: all selects at register file, no stall
    v = blank();
    apply("R1 idle", "R8 idle", "R11 idle", "R6 idle");

    // R1: ALU result one ahead
    v = blank(); v.ex_rs1 = 1; v.ex_rs2 = 2; v.mem_rd = 1; v.mem_we = 1;
    apply("R1", "R8", "R11", "R6");
    if (fwd_a !== 2'b10) begin bad++; $display("FAIL R1 fwd_a actual=%0b expected=10", fwd_a); end
    total++;

    // R2: result two ahead
    v = blank(); v.ex_rs2 = 3; v.wb_rd = 3; v.wb_we = 1;
    apply("R2", "R8", "R11", "R6");

    // R3: both stages write the same register
    v = blank(); v.ex_rs1 = 4; v.ex_rs2 = 4; v.mem_rd = 4; v.mem_we = 1; v.wb_rd = 4; v.wb_we = 1;
    apply("R3", "R8", "R11", "R6");

    // R4: register 0 producers everywhere
    v = blank(); v.id_rs1 = 0; v.use1 = 1; v.id_br = 1; v.ex_rd = 0; v.ex_we = 1; v.ex_ld = 1;
    v.mem_rd = 0; v.mem_we = 1; v.mem_st = 1; v.mem_rs2 = 0; v.wb_rd = 0; v.wb_we = 1;
    apply("R4", "R4", "R4", "R4");

    // R5: load one ahead, older write-back to same register
    v = blank(); v.ex_rs1 = 5; v.mem_rd = 5; v.mem_we = 1; v.mem_ld = 1; v.wb_rd = 5; v.wb_we = 1;
    apply("R5", "R8", "R11", "R6");

    // R6: load-use on rs1, then on rs2 of an ALU op
    v = blank(); v.id_rs1 = 6; v.use1 = 1; v.ex_rd = 6; v.ex_we = 1; v.ex_ld = 1;
    apply("R1", "R8", "R11", "R6");
    v = blank(); v.id_rs2 = 7; v.use2 = 1; v.ex_rd = 7; v.ex_we = 1; v.ex_ld = 1;
    apply("R1", "R8", "R11", "R6");
    // R6: unused source does not stall
    v = blank(); v.id_rs1 = 6; v.use1 = 0; v.ex_rd = 6; v.ex_we = 1; v.ex_ld = 1;
    apply("R1", "R8", "R11", "R6");

    // R7: load then store of the loaded register: no stall, then store-data bypass (R8)
    v = blank(); v.id_rs1 = 2; v.id_rs2 = 9; v.use1 = 1; v.use2 = 1; v.id_st = 1;
    v.ex_rd = 9; v.ex_we = 1; v.ex_ld = 1;
    apply("R1", "R8", "R11", "R7");
    v = blank(); v.mem_st = 1; v.mem_rs2 = 9; v.wb_rd = 9; v.wb_we = 1;
    apply("R1", "R8", "R11", "R6");
    v = blank(); v.mem_st = 0; v.mem_rs2 = 9; v.wb_rd = 9; v.wb_we = 1;
    apply("R1", "R8", "R11", "R6");

    // R9: ALU producer in execute feeds branch
    v = blank(); v.id_br = 1; v.id_rs1 = 10; v.id_rs2 = 11; v.use1 = 1; v.use2 = 1;
    v.ex_rd = 11; v.ex_we = 1;
    apply("R1", "R8", "R11", "R9");
    // next cycle: value in memory stage, comparator bypass, no stall
    v = blank(); v.id_br = 1; v.id_rs1 = 10; v.id_rs2 = 11; v.use1 = 1; v.use2 = 1;
    v.mem_rd = 11; v.mem_we = 1;
    apply("R1", "R8", "R11", "R9");

    // R10: load in memory stage feeds branch
    v = blank(); v.id_br = 1; v.id_rs1 = 12; v.use1 = 1; v.mem_rd = 12; v.mem_we = 1; v.mem_ld = 1;
    apply("R1", "R8", "R11", "R10");

    // random dense sweep over registers 0..3
    for (int n = 0; n < 3000; n++) begin
      v.id_rs1 = $urandom_range(0, 3); v.id_rs2 = $urandom_range(0, 3);
      v.use1 = $urandom_range(0, 1); v.use2 = $urandom_range(0, 1);
      v.id_st = $urandom_range(0, 1); v.id_br = $urandom_range(0, 1);
      v.ex_rs1 = $urandom_range(0, 3); v.ex_rs2 = $urandom_range(0, 3); v.ex_rd = $urandom_range(0, 3);
      v.ex_we = $urandom_range(0, 1); v.ex_ld = $urandom_range(0, 1);
      v.mem_rd = $urandom_range(0, 3); v.mem_we = $urandom_range(0, 1);
      v.mem_ld = $urandom_range(0, 1); v.mem_st = $urandom_range(0, 1); v.mem_rs2 = $urandom_range(0, 3);
      v.wb_rd = $urandom_range(0, 3); v.wb_we = $urandom_range(0, 1);
      apply("R3 sweep", "R8 sweep", "R11 sweep", "R6 sweep");
    end

    finish_run();
  end
endmodule